// File: doc/BRIEF.md
# Staged Clock-Slowdown Sleep Sequencer

This block is a synchronous controller that takes a processor core into a low-power sleep and back out again. When a sleep request arrives in the run state, the block slows the core clock in three timed stages. It does this by driving two divider-select codes to an external clock generator. A single reloadable down-counter paces the stages. The block then waits, for as long as it takes, for an interrupt whose enable bit is set.

On wake, the block first sets the divider codes back to full speed and waits for the clock generator to report that the ramp is complete. It then issues a one-cycle start pulse to the internal array self-initialisation engine and waits for that engine to finish. Finally, it pulses a done signal and returns to the run state. From then on, its fetch-source select points at the system interface instead of the boot serial ROM, so the serial ROM is not reloaded. The PLL, the dividers and the self-init engine lie outside the block. Every pin is a plain control or status level, and no pin carries a data stream.

Top module: `sleep_seq`

## Requirements
- R1: A synchronous active-high `rst` sets the run state and clears the counter. It also sets `div_y` = 0, `div_z` = 0, `init_start` = 0, `wake_done` = 0 and `fetch_sys` = 0. In the divider codes, the value is log2 of the divide ratio, so 0/0 means full speed.
- R2: If `sleep_req` is sampled high in the run state, the codes stay at 0/0 for exactly 8205 cycles. After that they become `div_y` = 1 and `div_z` = 2, which selects divide by 2 and divide by 4 (half speed).
- R3: Exactly 4108 cycles after the R2 change, the codes become `div_y` = 4 and `div_z` = 5, which selects divide by 16 and divide by 32 (one sixteenth of full speed).
- R4: Exactly 264 cycles after the R3 change, the block enters the interrupt wait. It stays there with codes 4/5 for as long as no qualified interrupt occurs.
- R5: An interrupt is qualified only when its request and its own enable are both 1. These pairs are (`clk_irq`, `clk_irq_en`) and (`dev_irq`, `dev_irq_en`). A request whose enable is 0 has no effect in any state.
- R6: If a qualified interrupt is sampled during the wait, the codes return to 0/0 at the next clock edge. `init_start` stays 0 until `ramp_done` is sampled high. At that edge, `init_start` goes to 1 for exactly one cycle.
- R7: After the start pulse, the block holds until `init_done` is sampled high. At that edge, `wake_done` goes to 1 for exactly one cycle and the block returns to the run state.
- R8: `fetch_sys` goes to 1 on the same edge as the first `wake_done` pulse. It stays at 1 until reset.
- R9: A `sleep_req` sampled while the block is not in the run state is ignored.
- R10: A qualified interrupt sampled during any slowdown stage is held pending, and the wait then lasts exactly one cycle. A qualified interrupt sampled in the run state is not held.
- R11: The divider codes change only at stage transitions. The only sequence they follow is 0/0, then 1/2, then 4/5, then back to 0/0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter sleep (honoured only in the run state) |
| clk_irq | input | 1 | Clock interrupt request |
| clk_irq_en | input | 1 | Enable for the clock interrupt |
| dev_irq | input | 1 | Device interrupt request |
| dev_irq_en | input | 1 | Enable for the device interrupt |
| ramp_done | input | 1 | The clock generator has reached full speed |
| init_done | input | 1 | The array self-initialisation has finished |
| div_y | output | 3 | First divider select, log2 of the ratio |
| div_z | output | 3 | Second divider select, log2 of the ratio |
| init_start | output | 1 | One-cycle start pulse for self-initialisation |
| wake_done | output | 1 | One-cycle pulse when the block is back in the run state |
| fetch_sys | output | 1 | 1 selects the system interface as the fetch source |

## Verification
The following properties hold on every cycle, so the assertions check them continuously:
- the legal pairing and order of the divider codes;
- the single-cycle width of the start and done pulses;
- the causal link from `ramp_done` and `init_done` to those pulses;
- the rule that a slowdown only ends after a qualified or pending interrupt;
- the stickiness of the fetch select.

The exact stage lengths of 8205, 4108 and 264 cycles, the unbounded hold in the wait, and the masking of requests whose enable is low can only be shown by the bench's scenarios. The same applies to the pending interrupt that shortens the wait to one cycle, the sleep requests that are ignored mid-sequence, and a reset during sleep. The bench's reference model checks each of these cycle by cycle.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_HOLD,
    ST_SLOW1,
    ST_SLOW2,
    ST_WAIT,
    ST_RAMP,
    ST_INIT
  } seq_state_e;

  localparam int DIV_W = 3;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sleep_seq_timer.sv
module sleep_seq_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             at_zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/sleep_seq_wake.sv
module sleep_seq_wake #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic            arm,
  input  logic            clear,
  output logic            wake_any
);
  logic [NSRC-1:0] qual;
  logic            pend_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign qual[i] = irq_req[i] & irq_en[i];
  end

  always_ff @(posedge clk) begin
    if (rst || clear)       pend_q <= 1'b0;
    else if (arm && |qual)  pend_q <= 1'b1;
  end

  assign wake_any = pend_q | (|qual);
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int HOLD_CYC  = 8205,
  parameter int SLOW1_CYC = 4108,
  parameter int SLOW2_CYC = 264,
  parameter int Y_HALF    = 1,
  parameter int Z_HALF    = 2,
  parameter int Y_SIXT    = 4,
  parameter int Z_SIXT    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             clk_irq,
  input  logic             clk_irq_en,
  input  logic             dev_irq,
  input  logic             dev_irq_en,
  input  logic             ramp_done,
  input  logic             init_done,
  output logic [DIV_W-1:0] div_y,
  output logic [DIV_W-1:0] div_z,
  output logic             init_start,
  output logic             wake_done,
  output logic             fetch_sys
);
  localparam int CNT_W = $clog2(max3(HOLD_CYC, SLOW1_CYC, SLOW2_CYC) + 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SLOW1 = CNT_W'(SLOW1_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SLOW2 = CNT_W'(SLOW2_CYC - 1);

  seq_state_e       state_q;
  logic [DIV_W-1:0] y_q, z_q;
  logic             start_q, done_q, fetch_q;
  logic             ld, dec, at_zero, wake_any, in_stage;
  logic [CNT_W-1:0] ld_val;

  assign in_stage = (state_q == ST_HOLD) || (state_q == ST_SLOW1) ||
                    (state_q == ST_SLOW2);

  // Counter reload is decided from the current state and the stage end.
  always_comb begin
    ld     = 1'b0;
    ld_val = '0;
    unique case (state_q)
      ST_RUN:   if (sleep_req) begin ld = 1'b1; ld_val = LD_HOLD;  end
      ST_HOLD:  if (at_zero)   begin ld = 1'b1; ld_val = LD_SLOW1; end
      ST_SLOW1: if (at_zero)   begin ld = 1'b1; ld_val = LD_SLOW2; end
      default: ;
    endcase
    dec = in_stage;
  end

  sleep_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .dec      (dec),
    .at_zero  (at_zero)
  );

  sleep_seq_wake #(.NSRC(2)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .irq_req  ({dev_irq, clk_irq}),
    .irq_en   ({dev_irq_en, clk_irq_en}),
    .arm      (in_stage),
    .clear    (!(in_stage || state_q == ST_WAIT)),
    .wake_any (wake_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      y_q     <= '0;
      z_q     <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_RUN:   if (sleep_req) state_q <= ST_HOLD;
        ST_HOLD:  if (at_zero) begin
          state_q <= ST_SLOW1;
          y_q     <= DIV_W'(Y_HALF);
          z_q     <= DIV_W'(Z_HALF);
        end
        ST_SLOW1: if (at_zero) begin
          state_q <= ST_SLOW2;
          y_q     <= DIV_W'(Y_SIXT);
          z_q     <= DIV_W'(Z_SIXT);
        end
        ST_SLOW2: if (at_zero) state_q <= ST_WAIT;
        ST_WAIT:  if (wake_any) begin
          state_q <= ST_RAMP;
          y_q     <= '0;
          z_q     <= '0;
        end
        ST_RAMP:  if (ramp_done) begin
          state_q <= ST_INIT;
          start_q <= 1'b1;
        end
        ST_INIT:  if (init_done) begin
          state_q <= ST_RUN;
          done_q  <= 1'b1;
          fetch_q <= 1'b1;
        end
        default:  state_q <= ST_RUN;
      endcase
    end
  end

  assign div_y      = y_q;
  assign div_z      = z_q;
  assign init_start = start_q;
  assign wake_done  = done_q;
  assign fetch_sys  = fetch_q;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
  parameter int DW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          ramp_done,
  input logic          init_done,
  input logic          wake_any,
  input logic [DW-1:0] div_y,
  input logic [DW-1:0] div_z,
  input logic          init_start,
  input logic          wake_done,
  input logic          fetch_sys
);
  AST_RESET_FULL_SPEED: assert property (@(posedge clk)
    rst |=> (div_y == 0 && div_z == 0 && !init_start && !wake_done && !fetch_sys)); // R1

  AST_CODE_PAIR: assert property (@(posedge clk) disable iff (rst)
    (div_y == 0 && div_z == 0) || (div_y == 1 && div_z == 2) || (div_y == 4 && div_z == 5)); // R3

  AST_CODE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (div_y != $past(div_y)) |->
      ((div_y == 1 && $past(div_y) == 0) || (div_y == 4 && $past(div_y) == 1) ||
       (div_y == 0 && $past(div_y) == 4))); // R11

  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (rst)
    (div_y == 0 && $past(div_y) == 4) |-> $past(wake_any)); // R5

  AST_START_AFTER_RAMP: assert property (@(posedge clk) disable iff (rst)
    init_start |-> $past(ramp_done)); // R6

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    init_start |=> !init_start); // R6

  AST_DONE_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
    wake_done |-> $past(init_done)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wake_done |=> !wake_done); // R7

  AST_FETCH_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    wake_done |-> fetch_sys); // R8

  AST_FETCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    fetch_sys |=> fetch_sys); // R8
endmodule

bind sleep_seq sleep_seq_chk #(.DW(sleep_seq_pkg::DIV_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ramp_done  (ramp_done),
  .init_done  (init_done),
  .wake_any   (wake_any),
  .div_y      (div_y),
  .div_z      (div_z),
  .init_start (init_start),
  .wake_done  (wake_done),
  .fetch_sys  (fetch_sys)
);

// File: tb/sleep_seq_tb.sv
`timescale 1ns/1ps
module sleep_seq_tb;
  localparam int T0 = 8205;
  localparam int T1 = 4108;
  localparam int T2 = 264;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 0, clk_irq = 0, clk_irq_en = 0, dev_irq = 0, dev_irq_en = 0;
  logic ramp_done = 0, init_done = 0;
  logic [2:0] div_y, div_z;
  logic init_start, wake_done, fetch_sys;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit started = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  sleep_seq u_dut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req),
    .clk_irq(clk_irq), .clk_irq_en(clk_irq_en),
    .dev_irq(dev_irq), .dev_irq_en(dev_irq_en),
    .ramp_done(ramp_done), .init_done(init_done),
    .div_y(div_y), .div_z(div_z), .init_start(init_start),
    .wake_done(wake_done), .fetch_sys(fetch_sys)
  );

  // Behavioural reference: phase 0 run, 1..3 slowdown stages, 4 wait, 5 ramp, 6 self-init.
  int m_phase = 0;
  int m_left  = 0;
  bit m_pend  = 0;
  int m_y = 0, m_z = 0;
  bit m_is = 0, m_wd = 0, m_fs = 0;

  always @(posedge clk) begin
    bit q;
    cycles++;
    started = 1;
    q = (clk_irq && clk_irq_en) || (dev_irq && dev_irq_en);
    m_is = 0;
    m_wd = 0;
    if (rst) begin
      m_phase = 0; m_left = 0; m_pend = 0;
      m_y = 0; m_z = 0; m_fs = 0;
    end else begin
      if (m_phase >= 1 && m_phase <= 3 && q) m_pend = 1;
      case (m_phase)
        0: if (sleep_req) begin m_phase = 1; m_left = T0; end
        1: begin m_left--; if (m_left == 0) begin m_phase = 2; m_left = T1; m_y = 1; m_z = 2; end end
        2: begin m_left--; if (m_left == 0) begin m_phase = 3; m_left = T2; m_y = 4; m_z = 5; end end
        3: begin m_left--; if (m_left == 0) m_phase = 4; end
        4: if (q || m_pend) begin m_phase = 5; m_pend = 0; m_y = 0; m_z = 0; end
        5: if (ramp_done) begin m_phase = 6; m_is = 1; end
        6: if (init_done) begin m_phase = 0; m_wd = 1; m_fs = 1; end
        default: m_phase = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  function automatic string div_tag(input int p);
    if (p == 2) return "R2 divider codes";
    if (p == 3 || p == 4) return "R3 divider codes";
    if (p == 5 || p == 6) return "R6 divider codes";
    return "R11 divider codes";
  endfunction

  always @(negedge clk) begin
    if (started && !ended) begin
      check(div_y == 3'(m_y), div_tag(m_phase), div_y, m_y);
      check(div_z == 3'(m_z), div_tag(m_phase), div_z, m_z);
      check(init_start == m_is, "R6 init_start", init_start, m_is);
      check(wake_done == m_wd, "R7 wake_done", wake_done, m_wd);
      check(fetch_sys == m_fs, "R8 fetch_sys", fetch_sys, m_fs);
    end
  end

  task automatic finish_up();
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 150000 && !ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_up();
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_y(input int v);
    while (div_y != 3'(v)) @(negedge clk);
  endtask

  initial begin
    int n;
    tick(3);
    rst = 0;
    // R1 reset state
    check(div_y == 0 && div_z == 0, "R1 reset codes", div_y, 0);
    check(!init_start && !wake_done && !fetch_sys, "R1 reset flags", fetch_sys, 0);

    // Sleep 1: full sequence, masked requests, ignored sleep request.
    sleep_req = 1; tick(); sleep_req = 0;
    n = 0;
    while (div_y == 0) begin n++; tick(); end
    check(n == T0, "R2 hold length", n, T0);
    sleep_req = 1; tick(); sleep_req = 0;
    tick(10);
    check(div_y == 1, "R9 sleep_req mid-stage ignored", div_y, 1);
    wait_y(4);
    tick(T2 + 2);
    clk_irq = 1; dev_irq = 1;
    tick(500);
    check(div_y == 4 && div_z == 5, "R4 wait holds / R5 masked irq", div_y, 4);
    clk_irq = 0; dev_irq = 0;
    dev_irq = 1; dev_irq_en = 1; tick(); dev_irq = 0; dev_irq_en = 0;
    tick(5);
    check(div_y == 0 && !init_start, "R6 no start before ramp_done", init_start, 0);
    ramp_done = 1; tick(); ramp_done = 0;
    tick(3);
    init_done = 1; tick(); init_done = 0;
    tick(2);
    check(fetch_sys == 1, "R8 fetch after wake", fetch_sys, 1);

    // Sleep 2: enabled irq in run is not held; irq in stage is pending (R10).
    clk_irq = 1; clk_irq_en = 1; sleep_req = 1; tick();
    clk_irq = 0; clk_irq_en = 0; sleep_req = 0;
    wait_y(1);
    tick(7);
    clk_irq = 1; clk_irq_en = 1; tick(); clk_irq = 0; clk_irq_en = 0;
    wait_y(4);
    n = 0;
    while (div_y == 4) begin n++; tick(); end
    check(n == T2 + 1, "R10 pending wake", n, T2 + 1);
    ramp_done = 1; init_done = 1;
    while (!wake_done) tick();
    ramp_done = 0; init_done = 0;
    tick(3);

    // Sleep 3: reset during the second stage.
    sleep_req = 1; tick(); sleep_req = 0;
    wait_y(1);
    tick(20);
    rst = 1; tick(2); rst = 0;
    check(div_y == 0 && div_z == 0 && !fetch_sys, "R1 reset mid-sleep", fetch_sys, 0);
    tick(T0 + 50);
    check(div_y == 0, "R9 no sleep without request after reset", div_y, 0);
    finish_up();
  end
endmodule